// File: doc/BRIEF.md
# Triggered Event Derandomizer

This block sits between a front end that delivers one 32-bit sample per channel on every clock and a serial link that drains data at a fixed rate. Triggers arrive at random. Each accepted trigger opens a readout window of a programmable number of clock periods. Every sample from every channel in that window is copied into a private event slot. Later the slot is emptied, one 32-bit word per cycle, through a valid/ready port toward the link serializer.

Storage is counted in whole events. A fixed set of slots is used in circular order. A registered throttle output warns the trigger system when the number of free slots falls to a programmable level, so that it stops before the buffer overflows. A trigger that finds every slot taken is not stored. Instead it adds one to a saturating dead-time counter. Windows may overlap: a trigger that arrives while an earlier window is still filling starts its own slot at once, and the two slots hold separate copies of any shared samples.

Top module: `evt_derand`

## Requirements
- R1: With `rst_n` low at a rising edge, all slots are emptied. After that edge `dout_valid`, `thr_busy` and `lost_cnt` are all zero.
- R2: A trigger accepted at an edge stores `samp_in` from that edge and from the following W-1 edges as one event, where W is `win_len` sampled at the trigger. A `win_len` of 0 is taken as 1, and a value above W_MAX (32) is taken as W_MAX. The event is offered at the output only in the cycle after its final sample is stored.
- R3: A trigger is accepted whenever a slot is free, even on consecutive cycles and while earlier windows are still filling. Overlapping events each hold their own full set of samples.
- R4: The buffer holds DEPTH (16) events. A trigger that arrives while all slots are occupied is dropped and never reaches the output.
- R5: Each dropped trigger adds one to the 16-bit `lost_cnt`, which stops at 65535.
- R6: `thr_busy` is registered. In the cycle after an edge it is 1 exactly when the free-slot count after that edge is less than or equal to the `thr_slots` value sampled at that edge.
- R7: Events leave in trigger order. Within an event, all W samples of channel 0 leave first, oldest first, then those of channel 1, and so on. Channel c occupies bits [c*32 +: 32] of `samp_in`.
- R8: A word transfers on an edge where `dout_valid` and `dout_ready` are both 1. While `dout_valid` is 1 and `dout_ready` is 0, `dout_data` and `dout_last` hold their values.
- R9: `dout_last` is 1 on the final word of each event and 0 on every other word.
- R10: A slot is freed at the edge that transfers its last word. A trigger at a later edge may then be stored in that slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling and link clock |
| rst_n | input | 1 | Synchronous reset, active low |
| trig_in | input | 1 | Trigger pulse, one per cycle at most |
| win_len | input | 6 | Readout window length in clock periods |
| thr_slots | input | 5 | Free-slot level at or below which the throttle asserts |
| samp_in | input | 64 | One 32-bit sample per channel, channel 0 in the low bits |
| thr_busy | output | 1 | Registered throttle to the trigger system |
| lost_cnt | output | 16 | Saturating count of dropped triggers |
| dout_data | output | 32 | Output word |
| dout_valid | output | 1 | Output word is valid |
| dout_ready | input | 1 | Link side accepts the word |
| dout_last | output | 1 | Final word of an event |

## Verification
Suppose a slot state is wrong, so that an event is marked complete too early or a slot is released twice. This shows at the output within one event. Either a word arrives with the wrong sample stamp, or `dout_last` lands in the wrong place, or the count of drained events differs from the count of accepted triggers. The bench stamps every sample with its channel and cycle number, which exposes these errors. A wrong occupancy count shows up within one clock on `thr_busy` when the buffer is filled past the threshold, and on `lost_cnt` when the buffer is overfilled. Overlapping windows and stalled reads are driven on purpose, because those are the cases where a slot or read pointer that moves at the wrong time goes unnoticed otherwise.

// File: rtl/evt_derand_pkg.sv
`timescale 1ns/1ps
// Package: shared types for the event derandomizer.
// Assumes nothing beyond being compiled ahead of the modules that import it.
package evt_derand_pkg;

    // Life cycle of one event slot.
    typedef enum logic [1:0] {
        SLOT_FREE = 2'd0,
        SLOT_FILL = 2'd1,
        SLOT_DONE = 2'd2
    } slot_st_t;

endpackage

// File: rtl/evt_derand_slot.sv
`timescale 1ns/1ps
// Module: one event slot. It holds W_MAX samples for each of N_CH channels.
// It fills one sample per channel per clock after a start, and is marked
// done after the last sample of its window is written. It returns to free
// when the drain side releases it.
// Assumes: len_in is already clamped to 1..W_MAX. start only arrives while
// the slot is free, and release only arrives while the slot is done.
module evt_derand_slot
    import evt_derand_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int N_CH   = 2,
    parameter int W_MAX  = 32,
    localparam int CH_W  = (N_CH > 1) ? $clog2(N_CH) : 1,
    localparam int S_W   = (W_MAX > 1) ? $clog2(W_MAX) : 1,
    localparam int L_W   = $clog2(W_MAX + 1)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic [L_W-1:0]           len_in,
    input  logic [N_CH*DATA_W-1:0]   samp_in,
    input  logic                     release_i,
    input  logic [CH_W-1:0]          rd_ch,
    input  logic [S_W-1:0]           rd_s,
    output logic                     is_free,
    output logic                     is_done,
    output logic [L_W-1:0]           len_o,
    output logic [DATA_W-1:0]        rd_word
);

    slot_st_t        st;
    logic [L_W-1:0]  len_q;
    logic [S_W-1:0]  wr_s;
    logic            we;
    logic [S_W-1:0]  wsel;
    logic [DATA_W-1:0] chan_word [N_CH];

    // Write enable and sample index for the storage rows.
    always_comb begin
        we   = (st == SLOT_FREE && start) || (st == SLOT_FILL);
        wsel = (st == SLOT_FREE) ? '0 : wr_s;
    end

    // Slot state, latched window length and fill position.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st    <= SLOT_FREE;
            len_q <= '0;
            wr_s  <= '0;
        end else begin
            case (st)
                SLOT_FREE: if (start) begin
                    len_q <= len_in;
                    wr_s  <= S_W'(1);
                    st    <= (len_in == L_W'(1)) ? SLOT_DONE : SLOT_FILL;
                end
                SLOT_FILL: begin
                    wr_s <= wr_s + S_W'(1);
                    if (L_W'(wr_s) == len_q - L_W'(1)) st <= SLOT_DONE;
                end
                SLOT_DONE: if (release_i) st <= SLOT_FREE;
                default:   st <= SLOT_FREE;
            endcase
        end
    end

    // One storage row per channel, written in parallel.
    for (genvar c = 0; c < N_CH; c++) begin : g_ch
        logic [DATA_W-1:0] row [W_MAX];

        // Capture this channel's sample at the current fill position.
        always_ff @(posedge clk) begin
            if (we) row[wsel] <= samp_in[c*DATA_W +: DATA_W];
        end

        assign chan_word[c] = row[rd_s];
    end

    assign rd_word = chan_word[rd_ch];
    assign is_free = (st == SLOT_FREE);
    assign is_done = (st == SLOT_DONE);
    assign len_o   = len_q;

    // R2
    fill_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == SLOT_FILL) |-> (wr_s != '0) && (L_W'(wr_s) < len_q));

endmodule

// File: rtl/evt_derand_alloc.sv
`timescale 1ns/1ps
// Module: slot allocation. It accepts triggers while a slot is free and
// hands out slots in circular order. It keeps the occupied-slot count,
// derives the registered throttle, and counts dropped triggers with
// saturation.
// Assumes: rel pulses once per drained event, and only for an occupied slot.
module evt_derand_alloc #(
    parameter int DEPTH  = 16,
    parameter int LOST_W = 16,
    localparam int P_W   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int C_W   = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trig,
    input  logic              rel,
    input  logic [C_W-1:0]    thr,
    output logic              accept,
    output logic [P_W-1:0]    wr_ptr,
    output logic              busy,
    output logic [LOST_W-1:0] lost
);

    logic [C_W-1:0] used;
    logic [C_W-1:0] used_nx;

    // Accept while a slot is free. The occupancy after this edge follows.
    always_comb begin
        accept  = trig && (used != C_W'(DEPTH));
        used_nx = used + C_W'(accept) - C_W'(rel);
    end

    // Occupancy, write pointer, throttle and dead-time counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            used   <= '0;
            wr_ptr <= '0;
            busy   <= 1'b0;
            lost   <= '0;
        end else begin
            used <= used_nx;
            busy <= (C_W'(DEPTH) - used_nx) <= thr;
            if (accept)
                wr_ptr <= (wr_ptr == P_W'(DEPTH - 1)) ? '0 : wr_ptr + P_W'(1);
            if (trig && !accept && lost != {LOST_W{1'b1}})
                lost <= lost + LOST_W'(1);
        end
    end

    // R4
    used_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        used <= C_W'(DEPTH));

    // R5
    lost_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trig && used == C_W'(DEPTH) && lost != {LOST_W{1'b1}})
        |=> lost == $past(lost) + LOST_W'(1));

    // R6
    busy_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> busy == ((C_W'(DEPTH) - used) <= $past(thr)));

endmodule

// File: rtl/evt_derand_drain.sv
`timescale 1ns/1ps
// Module: drain control. It walks the head slot channel by channel and
// sample by sample, raises last on the final word, and releases the slot
// and advances the read pointer when that word is transferred.
// Assumes: head_done/head_len come from the slot at rd_ptr, and a done slot
// stays done until released.
module evt_derand_drain #(
    parameter int N_CH  = 2,
    parameter int W_MAX = 32,
    parameter int DEPTH = 16,
    localparam int CH_W = (N_CH > 1) ? $clog2(N_CH) : 1,
    localparam int S_W  = (W_MAX > 1) ? $clog2(W_MAX) : 1,
    localparam int L_W  = $clog2(W_MAX + 1),
    localparam int P_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            head_done,
    input  logic [L_W-1:0]  head_len,
    input  logic            dout_ready,
    output logic [P_W-1:0]  rd_ptr,
    output logic [CH_W-1:0] rd_ch,
    output logic [S_W-1:0]  rd_s,
    output logic            dout_valid,
    output logic            dout_last,
    output logic            rel
);

    logic fire;
    logic s_end;

    // Handshake and end-of-event decode.
    always_comb begin
        dout_valid = head_done;
        s_end      = (L_W'(rd_s) == head_len - L_W'(1));
        dout_last  = head_done && s_end && (rd_ch == CH_W'(N_CH - 1));
        fire       = dout_valid && dout_ready;
        rel        = fire && dout_last;
    end

    // Advance sample, then channel, then slot on each transfer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            rd_ch  <= '0;
            rd_s   <= '0;
        end else if (fire) begin
            if (s_end) begin
                rd_s <= '0;
                if (rd_ch == CH_W'(N_CH - 1)) begin
                    rd_ch  <= '0;
                    rd_ptr <= (rd_ptr == P_W'(DEPTH - 1)) ? '0 : rd_ptr + P_W'(1);
                end else begin
                    rd_ch <= rd_ch + CH_W'(1);
                end
            end else begin
                rd_s <= rd_s + S_W'(1);
            end
        end
    end

    // R7
    next_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !dout_last) |=> dout_valid);

endmodule

// File: rtl/evt_derand.sv
`timescale 1ns/1ps
// Module: triggered event derandomizer, top level. It clamps the window
// length, instantiates DEPTH event slots, and joins them to the allocation
// and drain control. The head slot's word is muxed to the output.
// Assumes: samp_in is valid on every clock, with channel c in bits
// [c*DATA_W +: DATA_W].
module evt_derand #(
    parameter int DATA_W = 32,
    parameter int N_CH   = 2,
    parameter int W_MAX  = 32,
    parameter int DEPTH  = 16,
    parameter int LOST_W = 16,
    localparam int CH_W  = (N_CH > 1) ? $clog2(N_CH) : 1,
    localparam int S_W   = (W_MAX > 1) ? $clog2(W_MAX) : 1,
    localparam int L_W   = $clog2(W_MAX + 1),
    localparam int P_W   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int C_W   = $clog2(DEPTH + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   trig_in,
    input  logic [L_W-1:0]         win_len,
    input  logic [C_W-1:0]         thr_slots,
    input  logic [N_CH*DATA_W-1:0] samp_in,
    output logic                   thr_busy,
    output logic [LOST_W-1:0]      lost_cnt,
    output logic [DATA_W-1:0]      dout_data,
    output logic                   dout_valid,
    input  logic                   dout_ready,
    output logic                   dout_last
);

    logic              accept;
    logic              rel;
    logic [P_W-1:0]    wr_ptr;
    logic [P_W-1:0]    rd_ptr;
    logic [CH_W-1:0]   rd_ch;
    logic [S_W-1:0]    rd_s;
    logic [L_W-1:0]    len_eff;
    logic              slot_free [DEPTH];
    logic              slot_done [DEPTH];
    logic [L_W-1:0]    slot_len  [DEPTH];
    logic [DATA_W-1:0] slot_word [DEPTH];

    // Clamp the requested window into 1..W_MAX.
    always_comb begin
        if (win_len == '0)               len_eff = L_W'(1);
        else if (win_len > L_W'(W_MAX))  len_eff = L_W'(W_MAX);
        else                             len_eff = win_len;
    end

    evt_derand_alloc #(.DEPTH(DEPTH), .LOST_W(LOST_W)) u_alloc (
        .clk    (clk),
        .rst_n  (rst_n),
        .trig   (trig_in),
        .rel    (rel),
        .thr    (thr_slots),
        .accept (accept),
        .wr_ptr (wr_ptr),
        .busy   (thr_busy),
        .lost   (lost_cnt)
    );

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        evt_derand_slot #(.DATA_W(DATA_W), .N_CH(N_CH), .W_MAX(W_MAX)) u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .start     (accept && (wr_ptr == P_W'(i))),
            .len_in    (len_eff),
            .samp_in   (samp_in),
            .release_i (rel && (rd_ptr == P_W'(i))),
            .rd_ch     (rd_ch),
            .rd_s      (rd_s),
            .is_free   (slot_free[i]),
            .is_done   (slot_done[i]),
            .len_o     (slot_len[i]),
            .rd_word   (slot_word[i])
        );
    end

    evt_derand_drain #(.N_CH(N_CH), .W_MAX(W_MAX), .DEPTH(DEPTH)) u_drain (
        .clk        (clk),
        .rst_n      (rst_n),
        .head_done  (slot_done[rd_ptr]),
        .head_len   (slot_len[rd_ptr]),
        .dout_ready (dout_ready),
        .rd_ptr     (rd_ptr),
        .rd_ch      (rd_ch),
        .rd_s       (rd_s),
        .dout_valid (dout_valid),
        .dout_last  (dout_last),
        .rel        (rel)
    );

    assign dout_data = slot_word[rd_ptr];

    // R3
    accept_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> slot_free[wr_ptr]);

    // R8
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dout_valid && !dout_ready)
        |=> dout_valid && $stable(dout_data) && $stable(dout_last));

endmodule

// File: tb/evt_derand_bench.sv
`timescale 1ns/1ps
// Bench: a table of trigger scenarios walked by one loop, then directed
// tests for reset, capture latency, throttle timing, slot reuse and
// counter saturation.
module evt_derand_bench;

    localparam int DEPTH = 16;
    localparam int NCH   = 2;
    localparam int WMAX  = 32;
    localparam int NROW  = 6;
    // columns: win, ntrig, gap, thr, ready mode, exp accepted, exp lost, exp busy
    localparam int ROWS [NROW][8] = '{
        '{10,  3, 2,  1, 0,  3, 0, 0},
        '{30,  5, 2,  1, 1,  5, 0, 0},
        '{ 1, 20, 2,  2, 0, 16, 4, 1},
        '{40,  2, 5, 14, 1,  2, 0, 1},
        '{ 0, 16, 1,  1, 1, 16, 0, 1},
        '{32, 17, 3,  0, 0, 16, 1, 1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        trig_in = 1'b0;
    logic [5:0]  win_len = 6'd1;
    logic [4:0]  thr_slots = 5'd1;
    logic [63:0] samp_in;
    logic        thr_busy;
    logic [15:0] lost_cnt;
    logic [31:0] dout_data;
    logic        dout_valid;
    logic        dout_ready = 1'b0;
    logic        dout_last;

    int tick = 0;
    int n_run = 0;
    int n_fail = 0;
    bit done_flag = 0;
    int m_used = 0;
    int m_lost = 0;
    int m_events = 0;
    logic [31:0] exp_q [$];
    bit          last_q [$];

    always #4 clk = ~clk;

    always @(posedge clk) tick <= tick + 1;

    // Each channel's sample carries the channel number and the cycle stamp.
    always_comb begin
        for (int c = 0; c < NCH; c++)
            samp_in[c*32 +: 32] = {8'(c), 8'hA5, 16'(tick)};
    end

    evt_derand u_evt_derand (
        .clk(clk), .rst_n(rst_n), .trig_in(trig_in), .win_len(win_len),
        .thr_slots(thr_slots), .samp_in(samp_in), .thr_busy(thr_busy),
        .lost_cnt(lost_cnt), .dout_data(dout_data), .dout_valid(dout_valid),
        .dout_ready(dout_ready), .dout_last(dout_last)
    );

    task automatic chk(bit ok, string req, string what, longint act, longint exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic int eff_w(int w);
        if (w == 0) return 1;
        if (w > WMAX) return WMAX;
        return w;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; trig_in = 1'b0; dout_ready = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        exp_q.delete(); last_q.delete();
        m_used = 0; m_lost = 0; m_events = 0;
    endtask

    // Queue the expected words of one accepted event (R7 order, R9 last).
    task automatic push_event(int t, int w);
        for (int c = 0; c < NCH; c++)
            for (int s = 0; s < w; s++) begin
                exp_q.push_back({8'(c), 8'hA5, 16'(t + s)});
                last_q.push_back(c == NCH - 1 && s == w - 1);
            end
    endtask

    task automatic fire(int n, int gap, int w);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            trig_in = 1'b1;
            if (m_used < DEPTH) begin
                push_event(tick, eff_w(w)); m_used++;
            end else if (m_lost < 65535) m_lost++;
            for (int g = 1; g < gap; g++) begin
                @(negedge clk); trig_in = 1'b0;
            end
        end
        @(negedge clk);
        trig_in = 1'b0;
    endtask

    // Pull nwords words; mode 1 toggles ready to force stalls.
    task automatic drain(int mode, int nwords);
        int idx = 0;
        int guard = 0;
        logic [31:0] held = '0;
        bit held_ok = 0;
        logic held_last = 1'b0;
        dout_ready = 1'b0;
        while (idx < nwords && guard < 5000) begin
            @(negedge clk);
            guard++;
            if (held_ok) begin
                chk(dout_data == held && dout_last == held_last, "R8", "stall hold",
                    dout_data, held);
                held_ok = 0;
            end
            dout_ready = (mode == 0) ? 1'b1 : ~dout_ready;
            if (dout_valid && dout_ready) begin
                logic [31:0] ew;
                bit el;
                ew = exp_q.pop_front();
                el = last_q.pop_front();
                chk(dout_data == ew, "R7", "word", dout_data, ew);
                chk(dout_last == el, "R9", "last flag", dout_last, el);
                if (el) begin m_used--; m_events++; end
                idx++;
            end else if (dout_valid) begin
                held = dout_data; held_last = dout_last; held_ok = 1;
            end
        end
        @(negedge clk);
        dout_ready = 1'b0;
        chk(idx == nwords, "R7", "words drained", idx, nwords);
    endtask

    initial begin
        #(8 * 200000);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        if (!done_flag) $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        // R1: reset state
        do_reset();
        @(negedge clk);
        chk(dout_valid == 1'b0, "R1", "valid after reset", dout_valid, 0);
        chk(thr_busy == 1'b0, "R1", "busy after reset", thr_busy, 0);
        chk(lost_cnt == 16'd0, "R1", "lost after reset", lost_cnt, 0);

        // Table of scenarios
        for (int r = 0; r < NROW; r++) begin
            do_reset();
            win_len = 6'(ROWS[r][0]);
            thr_slots = 5'(ROWS[r][3]);
            fire(ROWS[r][1], ROWS[r][2], ROWS[r][0]);
            repeat (WMAX + 3) @(negedge clk);
            chk(lost_cnt == 16'(ROWS[r][6]), "R5", "lost per row", lost_cnt, ROWS[r][6]);
            chk(thr_busy == 1'(ROWS[r][7]), "R6", "busy when loaded", thr_busy, ROWS[r][7]);
            drain(ROWS[r][4], exp_q.size());
            chk(m_events == ROWS[r][5], (ROWS[r][6] == 0) ? "R3" : "R4",
                "events drained", m_events, ROWS[r][5]);
            repeat (2) @(negedge clk);
            chk(dout_valid == 1'b0, "R4", "no extra event", dout_valid, 0);
            chk(thr_busy == 1'b0, "R6", "busy released", thr_busy, 0);
        end

        // R2: event appears only after its last sample
        do_reset();
        win_len = 6'd10;
        @(negedge clk); trig_in = 1'b1; push_event(tick, 10); m_used++;
        @(negedge clk); trig_in = 1'b0;
        repeat (8) @(negedge clk);
        chk(dout_valid == 1'b0, "R2", "valid before window end", dout_valid, 0);
        @(negedge clk);
        chk(dout_valid == 1'b1, "R2", "valid after window end", dout_valid, 1);
        drain(0, 20);

        // R6: throttle edge at threshold, then R10 slot reuse
        do_reset();
        win_len = 6'd2; thr_slots = 5'd1;
        for (int k = 1; k <= 15; k++) begin
            @(negedge clk); trig_in = 1'b1; push_event(tick, 2); m_used++;
            @(negedge clk); trig_in = 1'b0;
            if (k == 14) chk(thr_busy == 1'b0, "R6", "busy at 2 free", thr_busy, 0);
            if (k == 15) chk(thr_busy == 1'b1, "R6", "busy at 1 free", thr_busy, 1);
        end
        fire(2, 2, 2);
        chk(lost_cnt == 16'd1, "R4", "trigger dropped when full", lost_cnt, 1);
        repeat (4) @(negedge clk);
        drain(0, 4);
        chk(thr_busy == 1'b1, "R6", "busy with one free", thr_busy, 1);
        fire(1, 2, 2);
        chk(lost_cnt == 16'd1, "R10", "freed slot reused", lost_cnt, 1);
        repeat (4) @(negedge clk);
        drain(1, exp_q.size());
        chk(m_events == 17, "R10", "events after reuse", m_events, 17);

        // R5: saturation of the dead-time counter
        do_reset();
        win_len = 6'd1;
        fire(DEPTH + 65535 + 10, 1, 1);
        chk(lost_cnt == 16'hFFFF, "R5", "lost saturates", lost_cnt, 16'hFFFF);
        do_reset();
        @(negedge clk);
        chk(lost_cnt == 16'd0, "R1", "lost cleared by reset", lost_cnt, 0);
        chk(dout_valid == 1'b0, "R1", "buffer emptied by reset", dout_valid, 0);

        done_flag = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule